// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit performs one shift or rotate operation on an 8-bit or 16-bit operand and produces the result together with the new status flags. Each flag comes with its own write-enable, so the surrounding datapath knows which flags to commit. There are seven operations: shift left, logical shift right, arithmetic shift right, rotate left, rotate right, and rotate left or right through carry. The distance is either the constant 1 or an 8-bit count value. The incoming carry and overflow enter with the operand.

The operation runs one bit position per clock cycle. A start pulse loads the operand, the operation and the count. The unit then steps until the count is used up, raises a one-cycle done pulse and holds the result and flag outputs until the next operation completes. In byte mode, bit 7 acts as the sign bit and the upper byte of the operand passes to the result unchanged.

Top module: `shift_rotate_unit`

## Requirements
- R1: After reset, busy_o, done_o, result_o and every flag and write-enable output are 0.
- R2: start_i is accepted only while busy_o is low. done_o pulses for exactly one cycle, N+1 clock cycles after the edge that accepted the start, where N is the effective count. A start_i raised while busy_o is high is ignored and does not change the running operation.
- R3: With cnt_sel_i=0 the count is 1 whatever cnt_i holds. With cnt_sel_i=1 the count is the full 8-bit cnt_i, from 0 to 255, without masking.
- R4: op_i encodes 0 shift left, 1 logical right, 2 arithmetic right, 3 rotate left, 4 rotate right, 5 rotate left through carry, 6 rotate right through carry, and 7 no operation. Both logical shifts fill vacated bits with 0, and CF is the last bit shifted out.
- R5: Arithmetic right shift refills the sign bit from the original sign bit (byte B0h by one gives D8h).
- R6: A plain rotate puts the bit that leaves one end into the other end and into CF (F0h left by 1 gives E1h; 3Fh by 4 either way gives F3h).
- R7: A rotate through carry treats CF as an extra bit in the loop. Left: 88h with CF=0 gives 10h with CF=1. Right: 10h with CF=1 gives 88h with CF=0.
- R8: Shifts with a nonzero count write CF, SF, ZF and PF. SF is the sign bit of the sized result. ZF is 1 when the sized result is zero. PF is 1 when the low byte of the result has an even number of ones.
- R9: Rotates with a nonzero count write only CF, and OF when the count is 1. sf/zf/pf write-enables stay 0 and those values read 0.
- R10: For a count of 1, OF is written as follows. For left operations OF is the new sign bit XOR the new CF. For logical right it is the original sign bit. For arithmetic right it is 0. For right rotates it is the XOR of the top two bits of the result. For any other count of a valid operation, of_we_o=0 and of_o=0.
- R11: A count of 0, or op 7, gives result_o equal to the operand, cf_o=cf_i and of_o=of_i, with all write-enables 0.
- R12: wide_i=1 uses bit 15 as the sign bit. wide_i=0 uses bit 7, and result_o[15:8] equals operand_i[15:8].
- R13: af_o and af_we_o are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted while idle |
| op_i | input | 3 | Operation code |
| wide_i | input | 1 | 1: 16-bit operand, 0: 8-bit operand |
| cnt_sel_i | input | 1 | 0: count of 1, 1: count from cnt_i |
| cnt_i | input | 8 | Count value |
| operand_i | input | 16 | Operand |
| cf_i | input | 1 | Incoming carry |
| of_i | input | 1 | Incoming overflow |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Result, held until next completion |
| cf_o | output | 1 | New carry |
| cf_we_o | output | 1 | Carry write-enable |
| of_o | output | 1 | New overflow |
| of_we_o | output | 1 | Overflow write-enable |
| sf_o | output | 1 | New sign |
| sf_we_o | output | 1 | Sign write-enable |
| zf_o | output | 1 | New zero |
| zf_we_o | output | 1 | Zero write-enable |
| pf_o | output | 1 | New parity |
| pf_we_o | output | 1 | Parity write-enable |
| af_o | output | 1 | Auxiliary carry, always 0 |
| af_we_o | output | 1 | Auxiliary carry write-enable, always 0 |

## Verification
The assertions watch the control on every cycle:

- the done pulse lasts one cycle and never coincides with busy;
- the remaining count drops by exactly one per step;
- the upper byte stays frozen during a byte operation;
- no rotate raises a sign, zero or parity write-enable;
- OF is written only for a count of one.

Only the bench scenarios can show that the values are right. These include the bit patterns that each operation produces, the carry chains of the through-carry rotates, the parity and zero flags and the latency. They also cover the effect of counts larger than the operand width and the fact that a start raised during a busy run is ignored.

// File: rtl/sru_pkg.sv
package sru_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_NOP = 3'd7
  } sru_op_e;

  function automatic logic is_shift(sru_op_e op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
  endfunction

  function automatic logic is_rotate(sru_op_e op);
    return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction

  function automatic logic is_left(sru_op_e op);
    return (op == OP_SHL) || (op == OP_ROL) || (op == OP_RCL);
  endfunction
endpackage

// File: rtl/sru_step.sv
module sru_step
  import sru_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              wide_i,
  input  sru_op_e           op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] data_o,
  output logic              cf_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);

  logic [IDX_W-1:0] msb_idx;
  logic             msb, lsb, fill;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    msb_idx = wide_i ? IDX_W'(DATA_W-1) : IDX_W'(HALF_W-1);
    msb     = data_i[msb_idx];
    lsb     = data_i[0];
    unique case (op_i)
      OP_SAR:         fill = msb;
      OP_ROL:         fill = msb;
      OP_ROR:         fill = lsb;
      OP_RCL, OP_RCR: fill = cf_i;
      default:        fill = 1'b0;
    endcase
    if (is_left(op_i)) begin
      nxt    = data_i << 1;
      nxt[0] = fill;
      cf_o   = msb;
    end else begin
      nxt          = data_i >> 1;
      nxt[msb_idx] = fill;
      cf_o         = lsb;
    end
    // byte mode: upper half never moves
    if (!wide_i) nxt[DATA_W-1:HALF_W] = data_i[DATA_W-1:HALF_W];
    if (op_i == OP_NOP) begin
      nxt  = data_i;
      cf_o = cf_i;
    end
    data_o = nxt;
  end
endmodule

// File: rtl/sru_flag_eval.sv
module sru_flag_eval
  import sru_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              wide_i,
  input  sru_op_e           op_i,
  input  logic              orig_msb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cf_i,
  output logic              sf_o,
  output logic              zf_o,
  output logic              pf_o,
  output logic              of1_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);

  logic [IDX_W-1:0] msb_idx, nmsb_idx;
  logic             msb, nmsb;

  always_comb begin
    msb_idx  = wide_i ? IDX_W'(DATA_W-1) : IDX_W'(HALF_W-1);
    nmsb_idx = msb_idx - IDX_W'(1);
    msb      = data_i[msb_idx];
    nmsb     = data_i[nmsb_idx];
    sf_o     = msb;
    zf_o     = wide_i ? (data_i == '0) : (data_i[HALF_W-1:0] == '0);
    pf_o     = ~^data_i[7:0];
    unique case (op_i)
      OP_SHR:         of1_o = orig_msb_i;
      OP_SAR:         of1_o = 1'b0;
      OP_ROR, OP_RCR: of1_o = msb ^ nmsb;
      OP_NOP:         of1_o = 1'b0;
      default:        of1_o = msb ^ cf_i;
    endcase
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import sru_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              wide_i,
  input  logic              cnt_sel_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              cf_i,
  input  logic              of_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              cf_o,
  output logic              cf_we_o,
  output logic              of_o,
  output logic              of_we_o,
  output logic              sf_o,
  output logic              sf_we_o,
  output logic              zf_o,
  output logic              zf_we_o,
  output logic              pf_o,
  output logic              pf_we_o,
  output logic              af_o,
  output logic              af_we_o
);
  localparam int HALF_W = DATA_W / 2;

  logic              busy_q, done_q;
  logic [CNT_W-1:0]  rem_q;
  logic [DATA_W-1:0] work_q;
  logic              cf_q, of_in_q, wide_q, one_q, zero_q, orig_msb_q;
  sru_op_e           op_q;

  logic [DATA_W-1:0] res_q;
  logic              cf_out_q, cf_we_q, of_out_q, of_we_q;
  logic              sf_out_q, zf_out_q, pf_out_q, szp_we_q;

  logic [DATA_W-1:0] step_data;
  logic              step_cf;
  logic              ev_sf, ev_zf, ev_pf, ev_of1;
  logic              start_ok, valid_op, shift_op;
  logic [CNT_W-1:0]  cnt_eff;

  assign start_ok = start_i && !busy_q;
  assign cnt_eff  = cnt_sel_i ? cnt_i : CNT_W'(1);
  assign valid_op = (op_q != OP_NOP) && !zero_q;
  assign shift_op = is_shift(op_q);

  sru_step #(.DATA_W(DATA_W)) i_step (
    .wide_i (wide_q),
    .op_i   (op_q),
    .data_i (work_q),
    .cf_i   (cf_q),
    .data_o (step_data),
    .cf_o   (step_cf)
  );

  sru_flag_eval #(.DATA_W(DATA_W)) i_flags (
    .wide_i     (wide_q),
    .op_i       (op_q),
    .orig_msb_i (orig_msb_q),
    .data_i     (work_q),
    .cf_i       (cf_q),
    .sf_o       (ev_sf),
    .zf_o       (ev_zf),
    .pf_o       (ev_pf),
    .of1_o      (ev_of1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      rem_q      <= '0;
      work_q     <= '0;
      cf_q       <= 1'b0;
      of_in_q    <= 1'b0;
      wide_q     <= 1'b0;
      one_q      <= 1'b0;
      zero_q     <= 1'b0;
      orig_msb_q <= 1'b0;
      op_q       <= OP_NOP;
      res_q      <= '0;
      cf_out_q   <= 1'b0;
      cf_we_q    <= 1'b0;
      of_out_q   <= 1'b0;
      of_we_q    <= 1'b0;
      sf_out_q   <= 1'b0;
      zf_out_q   <= 1'b0;
      pf_out_q   <= 1'b0;
      szp_we_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q     <= 1'b1;
        rem_q      <= cnt_eff;
        work_q     <= operand_i;
        cf_q       <= cf_i;
        of_in_q    <= of_i;
        wide_q     <= wide_i;
        op_q       <= sru_op_e'(op_i);
        one_q      <= (cnt_eff == CNT_W'(1));
        zero_q     <= (cnt_eff == '0);
        orig_msb_q <= wide_i ? operand_i[DATA_W-1] : operand_i[HALF_W-1];
      end else if (busy_q) begin
        if (rem_q != '0) begin
          work_q <= step_data;
          cf_q   <= step_cf;
          rem_q  <= rem_q - CNT_W'(1);
        end else begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          res_q    <= work_q;
          cf_out_q <= cf_q;
          cf_we_q  <= valid_op;
          of_out_q <= valid_op ? (one_q & ev_of1) : of_in_q;
          of_we_q  <= valid_op && one_q;
          sf_out_q <= valid_op && shift_op && ev_sf;
          zf_out_q <= valid_op && shift_op && ev_zf;
          pf_out_q <= valid_op && shift_op && ev_pf;
          szp_we_q <= valid_op && shift_op;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = res_q;
  assign cf_o     = cf_out_q;
  assign cf_we_o  = cf_we_q;
  assign of_o     = of_out_q;
  assign of_we_o  = of_we_q;
  assign sf_o     = sf_out_q;
  assign zf_o     = zf_out_q;
  assign pf_o     = pf_out_q;
  assign sf_we_o  = szp_we_q;
  assign zf_we_o  = szp_we_q;
  assign pf_we_o  = szp_we_q;
  assign af_o     = 1'b0;
  assign af_we_o  = 1'b0;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_done_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (rem_q != '0) |=> rem_q == $past(rem_q) - CNT_W'(1));

  assert_upper_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !wide_q |=> work_q[DATA_W-1:HALF_W] == $past(work_q[DATA_W-1:HALF_W]));

  assert_rot_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && is_rotate(op_q) |-> !sf_we_o && !zf_we_o && !pf_we_o);

  assert_of_we_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && of_we_o |-> one_q);
endmodule

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        wide = 1'b0;
  logic        cnt_sel = 1'b0;
  logic [7:0]  cnt = '0;
  logic [15:0] operand = '0;
  logic        cf_in = 1'b0;
  logic        of_in = 1'b0;
  logic        busy, done;
  logic [15:0] result;
  logic        cf, cf_we, of, of_we, sf, sf_we, zf, zf_we, pf, pf_we, af, af_we;

  int total = 0;
  int bad   = 0;

  logic [15:0] e_res;
  logic        e_cf, e_of, e_sf, e_zf, e_pf, e_cfwe, e_ofwe, e_szpwe;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rotate_unit i_shift_rotate_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
    .cnt_sel_i(cnt_sel), .cnt_i(cnt), .operand_i(operand), .cf_i(cf_in), .of_i(of_in),
    .busy_o(busy), .done_o(done), .result_o(result),
    .cf_o(cf), .cf_we_o(cf_we), .of_o(of), .of_we_o(of_we),
    .sf_o(sf), .sf_we_o(sf_we), .zf_o(zf), .zf_we_o(zf_we),
    .pf_o(pf), .pf_we_o(pf_we), .af_o(af), .af_we_o(af_we)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input int opc, input int w16, input int n, input logic [15:0] d,
                       input logic ci, input logic oi);
    int w, mask, top, v, c, nc, omsb, m1, m2, of1;
    logic [7:0] lb;
    logic valid, shf;
    w = w16 ? 16 : 8;
    mask = (1 << w) - 1;
    top = 1 << (w - 1);
    v = int'(d) & mask;
    c = int'(ci);
    omsb = (v >> (w - 1)) & 1;
    for (int i = 0; i < n; i++) begin
      case (opc)
        0: begin c = (v >> (w-1)) & 1; v = (v << 1) & mask; end
        1: begin c = v & 1; v = v >> 1; end
        2: begin c = v & 1; v = (v >> 1) | (v & top); end
        3: begin c = (v >> (w-1)) & 1; v = ((v << 1) & mask) | c; end
        4: begin c = v & 1; v = (v >> 1) | (c << (w-1)); end
        5: begin nc = (v >> (w-1)) & 1; v = ((v << 1) & mask) | c; c = nc; end
        6: begin nc = v & 1; v = (v >> 1) | (c << (w-1)); c = nc; end
        default: ;
      endcase
    end
    e_res = w16 ? v[15:0] : {d[15:8], v[7:0]};
    valid = (opc != 7) && (n != 0);
    shf = (opc < 3);
    m1 = (v >> (w-1)) & 1;
    m2 = (v >> (w-2)) & 1;
    case (opc)
      1: of1 = omsb;
      2: of1 = 0;
      4, 6: of1 = m1 ^ m2;
      default: of1 = m1 ^ c;
    endcase
    lb = v[7:0];
    e_cf    = valid ? c[0] : ci;
    e_cfwe  = valid;
    e_ofwe  = valid && (n == 1);
    e_of    = e_ofwe ? of1[0] : (valid ? 1'b0 : oi);
    e_szpwe = valid && shf;
    e_sf    = e_szpwe && m1[0];
    e_zf    = e_szpwe && (v == 0);
    e_pf    = e_szpwe && ~^lb;
  endtask

  // one operation; returns edges from accepting edge to done
  task automatic run(input int opc, input int w16, input logic sel, input int n,
                     input logic [15:0] d, input logic ci, input logic oi,
                     input bit poke, output int lat);
    op = 3'(opc); wide = w16[0]; cnt_sel = sel; cnt = 8'(n);
    operand = d; cf_in = ci; of_in = oi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 2) begin
        op = 3'd0; operand = 16'h0001; cnt_sel = 1'b1; cnt = 8'd1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  function automatic string res_tag(int opc, int w16, int n);
    if (opc == 7 || n == 0) return "R11";
    if (w16 == 0) return "R12";
    case (opc)
      0, 1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic full_check(input int opc, input int w16, input int n, input int lat);
    string tg;
    tg = res_tag(opc, w16, n);
    chk(tg, "result", 32'(result), 32'(e_res));
    chk((opc < 3 || opc == 7 || n == 0) ? "R8" : "R9", "cf/sf/zf/pf+we",
        32'({cf, cf_we, sf, sf_we, zf, zf_we, pf, pf_we}),
        32'({e_cf, e_cfwe, e_sf, e_szpwe, e_zf, e_szpwe, e_pf, e_szpwe}));
    chk("R10", "of+we", 32'({of, of_we}), 32'({e_of, e_ofwe}));
    chk("R13", "af+we", 32'({af, af_we}), 32'h0);
    chk("R2", "latency", 32'(lat), 32'(n + 1));
  endtask

  initial begin
    int lat;
    int counts [10] = '{0, 1, 2, 3, 4, 7, 8, 9, 16, 17};
    logic [15:0] pats [10] = '{16'h0000, 16'h0001, 16'h8000, 16'h0080, 16'h0088,
                               16'h12F0, 16'hC53F, 16'h7FFF, 16'hFFFF, 16'hA5C3};
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs",
        32'({busy, done, cf, cf_we, of, of_we, sf, sf_we, zf, zf_we, pf, pf_we}), 32'h0);
    chk("R1", "reset result", 32'(result), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed values
    run(3, 0, 1'b0, 1, 16'h00F0, 1'b0, 1'b0, 0, lat);
    chk("R6", "rol F0", 32'({result, cf}), {15'h0, 16'h00E1, 1'b1});
    run(3, 0, 1'b1, 4, 16'h003F, 1'b0, 1'b0, 0, lat);
    chk("R6", "rol 3F by 4", 32'(result), 32'h00F3);
    run(4, 0, 1'b1, 4, 16'h003F, 1'b0, 1'b0, 0, lat);
    chk("R6", "ror 3F by 4", 32'(result), 32'h00F3);
    run(5, 0, 1'b0, 1, 16'h0088, 1'b0, 1'b0, 0, lat);
    chk("R7", "rcl 88 step1", 32'({result, cf}), {15'h0, 16'h0010, 1'b1});
    run(5, 0, 1'b0, 1, result, cf, 1'b0, 0, lat);
    chk("R7", "rcl 88 step2", 32'({result, cf}), {15'h0, 16'h0021, 1'b0});
    run(6, 0, 1'b0, 1, 16'h0010, 1'b1, 1'b0, 0, lat);
    chk("R7", "rcr 10", 32'({result, cf}), {15'h0, 16'h0088, 1'b0});
    run(2, 0, 1'b0, 1, 16'h00B0, 1'b0, 1'b0, 0, lat);
    chk("R5", "sar byte -80", 32'({result, of, of_we}), {14'h0, 16'h00D8, 2'b01});
    run(2, 1, 1'b0, 1, 16'hFFB0, 1'b0, 1'b0, 0, lat);
    chk("R5", "sar word -80", 32'(result), 32'h0000FFD8);
    run(0, 0, 1'b0, 1, 16'hAB81, 1'b0, 1'b0, 0, lat);
    chk("R12", "byte shl upper kept", 32'({result, cf, of}), {14'h0, 16'hAB02, 2'b11});
    run(0, 1, 1'b0, 1, 16'h4000, 1'b0, 1'b0, 0, lat);
    chk("R12", "word shl sign bit15", 32'({result, sf, of}), {14'h0, 16'h8000, 2'b11});
    run(0, 1, 1'b0, 5, 16'h0001, 1'b0, 1'b0, 0, lat);
    chk("R3", "sel0 forces count 1", 32'({result, lat[7:0]}), {8'h0, 16'h0002, 8'd2});
    run(1, 1, 1'b1, 255, 16'hFFFF, 1'b1, 1'b0, 0, lat);
    chk("R3", "shr by 255", 32'({result, cf, of_we, lat[8:0]}), {5'h0, 16'h0000, 2'b00, 9'd256});
    run(3, 1, 1'b1, 255, 16'h0001, 1'b0, 1'b1, 0, lat);
    chk("R3", "rol by 255", 32'({result, cf, of, of_we}), {13'h0, 16'h8000, 3'b000});
    run(1, 1, 1'b1, 6, 16'h8000, 1'b0, 1'b0, 1, lat);
    chk("R2", "start while busy ignored", 32'({result, lat[7:0]}), {8'h0, 16'h0200, 8'd7});
    @(negedge clk);
    chk("R2", "done single pulse", 32'({done, busy}), 32'h0);
    run(7, 1, 1'b1, 3, 16'h1234, 1'b1, 1'b1, 0, lat);
    chk("R11", "nop", 32'({result, cf, of, cf_we, of_we, sf_we}), {11'h0, 16'h1234, 5'b11000});

    // sweep
    for (int w16 = 0; w16 < 2; w16++)
      for (int opc = 0; opc < 8; opc++)
        for (int ci = 0; ci < 10; ci++)
          for (int pi = 0; pi < 10; pi++)
            for (int cb = 0; cb < 2; cb++) begin
              logic oi;
              oi = pats[pi][3] ^ cb[0];
              model(opc, w16, counts[ci], pats[pi], cb[0], oi);
              run(opc, w16, 1'b1, counts[ci], pats[pi], cb[0], oi, 0, lat);
              full_check(opc, w16, counts[ci], lat);
            end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule